// File: doc/BRIEF.md
# Embedded Core Timer Unit

This block holds the three timers an embedded processor core uses for periodic work and for recovery from a hung program. A programmable interval timer (PIT) counts a software-loaded value down to expiry, either once or repeatedly. A fixed-interval timer (FIT) signals at one of four power-of-two periods. A watchdog escalates through three expiries: it arms, then interrupts, then requests a reset of the kind chosen in the control register. All counting advances only on cycles where the `tick` input is high, so the unit follows whatever time-base rate the core provides.

Software reaches the block through four plain write ports: the control word, a write-one-to-clear port for the status word, the PIT reload value, and a reset-kind port that asks for a core, chip or system reset directly. Each timer drives a level interrupt: the matching status bit ANDed with its enable bit in control. Reset requests are one-cycle pulses. When the watchdog and the software port ask for a reset on the same cycle, the more severe kind wins.

The PIT is a two-state machine: `PIT_IDLE` and `PIT_RUN`. It moves from idle to run on a reload write of more than 1 with the enable bit set, or on a control write that sets the enable bit while the stored reload is more than 1. It moves from run to idle on a control write that clears the enable bit, on a reload write of 0 or 1, or on an expiry without auto-reload. The watchdog stage is kept in the two status flags and decoded as `WD_QUIET` (arm flag clear), `WD_ARMED` (arm flag set, alert flag clear) and `WD_ALERT` (both flags set). An expiry in `WD_QUIET` sets the arm flag, an expiry in `WD_ARMED` sets the alert flag, and an expiry in `WD_ALERT` fires the reset action.

Top module: `core_tmr_unit`

## Requirements
- R1: After reset the control word, status word and PIT count read 0, and all interrupts and reset requests are low.
- R2: A running PIT loaded with value N expires on its Nth tick and sets status bit 27. `pit_irq` equals status bit 27 AND control bit 26.
- R3: On expiry with control bit 22 (auto-reload) set, the count reloads to N and the PIT keeps running. With bit 22 clear, the count goes to 0 and the PIT stops.
- R4: The PIT does not count while its reload value is 0 or 1, or after a control write clears bit 26. Its count holds during that time.
- R5: The FIT expires every 2^(FIT_LOG_MIN + LOG_STEP*s) ticks, where s is control bits 25:24 (defaults give 2^9, 2^13, 2^17, 2^21). Each expiry sets status bit 26. `fit_irq` equals status bit 26 AND control bit 23.
- R6: The watchdog expires every 2^(WDG_LOG_MIN + LOG_STEP*s) ticks, where s is control bits 31:30 (defaults give 2^17 to 2^29). The first expiry sets status bit 31. The next sets status bit 30, and `wdt_irq` equals status bit 30 AND control bit 27.
- R7: An expiry with status bits 31 and 30 both set copies control bits 29:28 into status bits 29:28 and pulses one reset request for one cycle: code 1 core, 2 chip, 3 system, 0 none.
- R8: A `dbg_we` write with `dbg_kind` equal to 1, 2 or 3 pulses the core, chip or system request on the following cycle. Kind 0 requests nothing.
- R9: Writing 1 to a status bit through `sts_we` clears that bit and leaves the others unchanged. A set on the same cycle takes precedence over the clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | Time-base advance enable |
| ctrl_we | input | 1 | Control word write strobe |
| ctrl_wdata | input | 32 | Control word write data (bits 31:22 kept) |
| sts_we | input | 1 | Status write-one-to-clear strobe |
| sts_wdata | input | 32 | Status bits to clear |
| pit_we | input | 1 | PIT reload write strobe |
| pit_wdata | input | PIT_W | PIT reload value |
| dbg_we | input | 1 | Software reset request strobe |
| dbg_kind | input | 2 | Requested reset kind (0 none, 1 core, 2 chip, 3 system) |
| ctrl_q | output | 32 | Control word |
| sts_q | output | 32 | Status word (bits 31:26 used) |
| pit_count | output | PIT_W | Current PIT count |
| pit_irq | output | 1 | PIT interrupt |
| fit_irq | output | 1 | FIT interrupt |
| wdt_irq | output | 1 | Watchdog interrupt |
| rst_core_req | output | 1 | Core reset request pulse |
| rst_chip_req | output | 1 | Chip reset request pulse |
| rst_sys_req | output | 1 | System reset request pulse |

## Verification
The assertions check on every cycle that an idle PIT holds its count, that a one-shot expiry leaves the PIT idle at zero, and that the period dividers wrap to zero after each expiry. They also check that the alert flag only rises on a cycle after the arm flag was set, that at most one reset request is active at a time, and that a software system-reset write is followed by its pulse. The bench scenarios are the only way to show the actual period lengths for each selector, the exact tick on which the PIT expires and reloads, and the full three-stage watchdog sequence ending in the correct reset kind. They also cover the masking of each interrupt by its enable bit.

// File: rtl/core_tmr_pkg.sv
package core_tmr_pkg;

    // control word bit positions
    localparam int C_WDG_SEL_LO = 30;
    localparam int C_WDG_KIND_LO = 28;
    localparam int C_WDG_IE = 27;
    localparam int C_PIT_EN = 26;
    localparam int C_FIT_SEL_LO = 24;
    localparam int C_FIT_IE = 23;
    localparam int C_PIT_AUTO = 22;

    // status word bit positions
    localparam int S_WDG_ARM = 31;
    localparam int S_WDG_ALERT = 30;
    localparam int S_RST_KIND_LO = 28;
    localparam int S_PIT_EXP = 27;
    localparam int S_FIT_EXP = 26;

    localparam logic [31:0] CTRL_MASK = 32'hFFC0_0000;
    localparam logic [31:0] STS_MASK = 32'hFC00_0000;

    typedef enum logic {
        PIT_IDLE = 1'b0,
        PIT_RUN  = 1'b1
    } pit_state_e;

    typedef enum logic [1:0] {
        WD_QUIET = 2'd0,
        WD_ARMED = 2'd1,
        WD_ALERT = 2'd2
    } wd_stage_e;

    typedef enum logic [1:0] {
        RK_NONE = 2'd0,
        RK_CORE = 2'd1,
        RK_CHIP = 2'd2,
        RK_SYS  = 2'd3
    } rst_kind_e;

endpackage

// File: rtl/core_tmr_period.sv
module core_tmr_period #(
    parameter int LOG_MIN = 9,
    parameter int LOG_STEP = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick,
    input  logic [1:0] sel,
    output logic       expire
);
    localparam int CW = LOG_MIN + 3 * LOG_STEP + 1;

    logic [CW-1:0] cnt_q;
    logic [CW-1:0] last_val;

    always_comb begin
        last_val = (CW'(1) << (LOG_MIN + LOG_STEP * int'(sel))) - CW'(1);
        expire   = tick && (cnt_q >= last_val);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (expire) begin
            cnt_q <= '0;
        end else if (tick) begin
            cnt_q <= cnt_q + CW'(1);
        end
    end

    // R5 / R6: a period always restarts from zero after it elapses
    assert_period_wrap_R5: assert property (@(posedge clk) disable iff (!rst_n)
        expire |=> (cnt_q == '0));

endmodule

// File: rtl/core_tmr_pit.sv
module core_tmr_pit
    import core_tmr_pkg::*;
#(
    parameter int PIT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             run_en,
    input  logic             auto_rl,
    input  logic             cfg_we,
    input  logic             cfg_en,
    input  logic             ld_we,
    input  logic [PIT_W-1:0] ld_val,
    output logic [PIT_W-1:0] count,
    output logic             expire
);
    localparam logic [PIT_W-1:0] ONE = PIT_W'(1);

    pit_state_e       st_q, st_n;
    logic [PIT_W-1:0] cnt_q, cnt_n;
    logic [PIT_W-1:0] rl_q, rl_n;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q  <= PIT_IDLE;
            cnt_q <= '0;
            rl_q  <= '0;
        end else begin
            st_q  <= st_n;
            cnt_q <= cnt_n;
            rl_q  <= rl_n;
        end
    end

    // transitions and outputs
    always_comb begin
        st_n   = st_q;
        cnt_n  = cnt_q;
        rl_n   = rl_q;
        expire = 1'b0;
        if (ld_we) begin
            rl_n  = ld_val;
            cnt_n = ld_val;
            st_n  = (run_en && (ld_val > ONE)) ? PIT_RUN : PIT_IDLE;
        end else begin
            unique case (st_q)
                PIT_IDLE: begin
                    if (cfg_we && cfg_en && (rl_q > ONE)) begin
                        st_n  = PIT_RUN;
                        cnt_n = rl_q;
                    end
                end
                PIT_RUN: begin
                    if (cfg_we && !cfg_en) begin
                        st_n = PIT_IDLE;
                    end else if (tick) begin
                        if (cnt_q <= ONE) begin
                            expire = 1'b1;
                            if (auto_rl) begin
                                cnt_n = rl_q;
                            end else begin
                                cnt_n = '0;
                                st_n  = PIT_IDLE;
                            end
                        end else begin
                            cnt_n = cnt_q - ONE;
                        end
                    end
                end
                default: st_n = PIT_IDLE;
            endcase
        end
    end

    assign count = cnt_q;

    // R4: an idle PIT keeps its count until software touches it
    assert_pit_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == PIT_IDLE && !ld_we && !cfg_we) |=> $stable(cnt_q));

    // R3: a one-shot expiry parks the PIT at zero
    assert_pit_oneshot_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (expire && !auto_rl) |=> (st_q == PIT_IDLE && cnt_q == '0));

endmodule

// File: rtl/core_tmr_wdog.sv
module core_tmr_wdog
    import core_tmr_pkg::*;
#(
    parameter int LOG_MIN = 17,
    parameter int LOG_STEP = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick,
    input  logic [1:0] sel,
    input  logic       flag_arm,
    input  logic       flag_alert,
    output logic       set_arm,
    output logic       set_alert,
    output logic       fire
);
    logic      expire;
    wd_stage_e stage;

    core_tmr_period #(
        .LOG_MIN (LOG_MIN),
        .LOG_STEP(LOG_STEP)
    ) u_period (
        .clk   (clk),
        .rst_n (rst_n),
        .tick  (tick),
        .sel   (sel),
        .expire(expire)
    );

    // stage decode from the status flags
    always_comb begin
        unique case ({flag_arm, flag_alert})
            2'b00:   stage = WD_QUIET;
            2'b01:   stage = WD_QUIET;
            2'b10:   stage = WD_ARMED;
            2'b11:   stage = WD_ALERT;
            default: stage = WD_QUIET;
        endcase
    end

    // stage actions
    always_comb begin
        set_arm   = 1'b0;
        set_alert = 1'b0;
        fire      = 1'b0;
        unique case (stage)
            WD_QUIET: set_arm   = expire;
            WD_ARMED: set_alert = expire;
            WD_ALERT: fire      = expire;
            default:  set_arm   = 1'b0;
        endcase
    end

endmodule

// File: rtl/core_tmr_rstreq.sv
module core_tmr_rstreq
    import core_tmr_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wd_fire,
    input  logic [1:0] wd_kind,
    input  logic       sw_fire,
    input  logic [1:0] sw_kind,
    output logic       req_core,
    output logic       req_chip,
    output logic       req_sys
);
    logic [1:0] wd_k, sw_k;
    rst_kind_e  pick;

    always_comb begin
        wd_k = wd_fire ? wd_kind : 2'd0;
        sw_k = sw_fire ? sw_kind : 2'd0;
        pick = rst_kind_e'((wd_k > sw_k) ? wd_k : sw_k);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            req_core <= 1'b0;
            req_chip <= 1'b0;
            req_sys  <= 1'b0;
        end else begin
            req_core <= (pick == RK_CORE);
            req_chip <= (pick == RK_CHIP);
            req_sys  <= (pick == RK_SYS);
        end
    end

    // R7: never more than one reset kind requested at once
    assert_rst_onehot_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({req_core, req_chip, req_sys}));

endmodule

// File: rtl/core_tmr_unit.sv
module core_tmr_unit
    import core_tmr_pkg::*;
#(
    parameter int PIT_W = 32,
    parameter int FIT_LOG_MIN = 9,
    parameter int WDG_LOG_MIN = 17,
    parameter int LOG_STEP = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             ctrl_we,
    input  logic [31:0]      ctrl_wdata,
    input  logic             sts_we,
    input  logic [31:0]      sts_wdata,
    input  logic             pit_we,
    input  logic [PIT_W-1:0] pit_wdata,
    input  logic             dbg_we,
    input  logic [1:0]       dbg_kind,
    output logic [31:0]      ctrl_q,
    output logic [31:0]      sts_q,
    output logic [PIT_W-1:0] pit_count,
    output logic             pit_irq,
    output logic             fit_irq,
    output logic             wdt_irq,
    output logic             rst_core_req,
    output logic             rst_chip_req,
    output logic             rst_sys_req
);
    logic        pit_exp, fit_exp;
    logic        wd_set_arm, wd_set_alert, wd_fire;
    logic [31:0] sts_n, clr_bits;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q <= '0;
        end else if (ctrl_we) begin
            ctrl_q <= ctrl_wdata & CTRL_MASK;
        end
    end

    core_tmr_pit #(.PIT_W(PIT_W)) u_pit (
        .clk    (clk),
        .rst_n  (rst_n),
        .tick   (tick),
        .run_en (ctrl_q[C_PIT_EN]),
        .auto_rl(ctrl_q[C_PIT_AUTO]),
        .cfg_we (ctrl_we),
        .cfg_en (ctrl_wdata[C_PIT_EN]),
        .ld_we  (pit_we),
        .ld_val (pit_wdata),
        .count  (pit_count),
        .expire (pit_exp)
    );

    core_tmr_period #(
        .LOG_MIN (FIT_LOG_MIN),
        .LOG_STEP(LOG_STEP)
    ) u_fit (
        .clk   (clk),
        .rst_n (rst_n),
        .tick  (tick),
        .sel   (ctrl_q[C_FIT_SEL_LO +: 2]),
        .expire(fit_exp)
    );

    core_tmr_wdog #(
        .LOG_MIN (WDG_LOG_MIN),
        .LOG_STEP(LOG_STEP)
    ) u_wdog (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick      (tick),
        .sel       (ctrl_q[C_WDG_SEL_LO +: 2]),
        .flag_arm  (sts_q[S_WDG_ARM]),
        .flag_alert(sts_q[S_WDG_ALERT]),
        .set_arm   (wd_set_arm),
        .set_alert (wd_set_alert),
        .fire      (wd_fire)
    );

    core_tmr_rstreq u_rstreq (
        .clk     (clk),
        .rst_n   (rst_n),
        .wd_fire (wd_fire),
        .wd_kind (ctrl_q[C_WDG_KIND_LO +: 2]),
        .sw_fire (dbg_we),
        .sw_kind (dbg_kind),
        .req_core(rst_core_req),
        .req_chip(rst_chip_req),
        .req_sys (rst_sys_req)
    );

    // status: clear by writing ones, event sets win
    always_comb begin
        clr_bits = sts_we ? (sts_wdata & STS_MASK) : 32'd0;
        sts_n    = sts_q & ~clr_bits;
        if (wd_set_arm)   sts_n[S_WDG_ARM]   = 1'b1;
        if (wd_set_alert) sts_n[S_WDG_ALERT] = 1'b1;
        if (pit_exp)      sts_n[S_PIT_EXP]   = 1'b1;
        if (fit_exp)      sts_n[S_FIT_EXP]   = 1'b1;
        if (wd_fire)      sts_n[S_RST_KIND_LO +: 2] = ctrl_q[C_WDG_KIND_LO +: 2];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sts_q <= '0;
        end else begin
            sts_q <= sts_n;
        end
    end

    always_comb begin
        pit_irq = sts_q[S_PIT_EXP]   & ctrl_q[C_PIT_EN];
        fit_irq = sts_q[S_FIT_EXP]   & ctrl_q[C_FIT_IE];
        wdt_irq = sts_q[S_WDG_ALERT] & ctrl_q[C_WDG_IE];
    end

    // R6: the alert flag only rises once the arm flag was already set
    assert_alert_after_arm_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sts_q[S_WDG_ALERT]) |-> $past(sts_q[S_WDG_ARM]));

    // R8: a software system-reset write yields its pulse next cycle
    assert_sw_sys_reset_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (dbg_we && dbg_kind == 2'd3) |=> rst_sys_req);

endmodule

// File: tb/core_tmr_unit_tb.sv
module core_tmr_unit_tb;
    localparam int PW = 16;

    // [15] 0=FIT 1=watchdog, [13:12] selector, [9:0] expected ticks
    localparam logic [15:0] VEC [8] = '{
        16'h0004, 16'h1008, 16'h2010, 16'h3020,
        16'h8008, 16'h9010, 16'hA020, 16'hB040
    };

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          tick = 1'b0;
    logic          ctrl_we = 1'b0, sts_we = 1'b0, pit_we = 1'b0, dbg_we = 1'b0;
    logic [31:0]   ctrl_wdata = '0, sts_wdata = '0;
    logic [PW-1:0] pit_wdata = '0;
    logic [1:0]    dbg_kind = '0;
    logic [31:0]   ctrl_q, sts_q;
    logic [PW-1:0] pit_count;
    logic          pit_irq, fit_irq, wdt_irq;
    logic          rst_core_req, rst_chip_req, rst_sys_req;

    int checks = 0;
    int fails = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    core_tmr_unit #(
        .PIT_W(PW), .FIT_LOG_MIN(2), .WDG_LOG_MIN(3), .LOG_STEP(1)
    ) u_dut (
        .clk(clk), .rst_n(rst_n), .tick(tick),
        .ctrl_we(ctrl_we), .ctrl_wdata(ctrl_wdata),
        .sts_we(sts_we), .sts_wdata(sts_wdata),
        .pit_we(pit_we), .pit_wdata(pit_wdata),
        .dbg_we(dbg_we), .dbg_kind(dbg_kind),
        .ctrl_q(ctrl_q), .sts_q(sts_q), .pit_count(pit_count),
        .pit_irq(pit_irq), .fit_irq(fit_irq), .wdt_irq(wdt_irq),
        .rst_core_req(rst_core_req), .rst_chip_req(rst_chip_req),
        .rst_sys_req(rst_sys_req)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    task automatic do_reset();
        tick = 1'b0;
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic wr_ctrl(input logic [31:0] d);
        @(negedge clk); ctrl_we = 1'b1; ctrl_wdata = d;
        @(negedge clk); ctrl_we = 1'b0;
    endtask

    task automatic wr_sts(input logic [31:0] d);
        @(negedge clk); sts_we = 1'b1; sts_wdata = d;
        @(negedge clk); sts_we = 1'b0;
    endtask

    task automatic wr_pit(input logic [PW-1:0] d);
        @(negedge clk); pit_we = 1'b1; pit_wdata = d;
        @(negedge clk); pit_we = 1'b0;
    endtask

    task automatic wr_dbg(input logic [1:0] k);
        @(negedge clk); dbg_we = 1'b1; dbg_kind = k;
        @(negedge clk); dbg_we = 1'b0;
    endtask

    task automatic run_ticks(input int n);
        tick = 1'b1;
        repeat (n) @(negedge clk);
        tick = 1'b0;
    endtask

    // which: 0 FIT flag, 1 arm flag, 2 alert flag, 3 PIT flag, 4 any reset pulse
    task automatic count_until(input int which, input int limit,
                               output int n, output logic [2:0] seen);
        logic hit;
        hit = 1'b0;
        n = 0;
        seen = 3'b000;
        tick = 1'b1;
        while (!hit && n < limit) begin
            @(negedge clk);
            n++;
            case (which)
                0: hit = sts_q[26];
                1: hit = sts_q[31];
                2: hit = sts_q[30];
                3: hit = sts_q[27];
                default: begin
                    seen = {rst_sys_req, rst_chip_req, rst_core_req};
                    hit = |seen;
                end
            endcase
        end
        tick = 1'b0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog expired actual=hung expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        int n;
        logic [2:0] seen;
        logic [15:0] v;

        // R1 reset state
        do_reset();
        chk("R1 ctrl after reset", ctrl_q, 32'h0);
        chk("R1 status after reset", sts_q, 32'h0);
        chk("R1 pit count after reset", 32'(pit_count), 32'h0);
        chk("R1 outputs after reset",
            {26'h0, pit_irq, fit_irq, wdt_irq, rst_core_req, rst_chip_req, rst_sys_req}, 32'h0);

        // period table: R5 FIT and R6 watchdog first stage
        for (int i = 0; i < 8; i++) begin
            v = VEC[i];
            do_reset();
            if (v[15]) begin
                wr_ctrl({v[13:12], 30'h0});
                count_until(1, 300, n, seen);
                chk($sformatf("R6 watchdog period sel=%0d", v[13:12]), 32'(n), 32'(v[9:0]));
            end else begin
                wr_ctrl({6'h0, v[13:12], 24'h0});
                count_until(0, 300, n, seen);
                chk($sformatf("R5 fit period sel=%0d", v[13:12]), 32'(n), 32'(v[9:0]));
            end
        end

        // R2 / R3 PIT one-shot
        do_reset();
        wr_ctrl(32'h0400_0000);
        wr_pit(16'd5);
        chk("R2 pit loaded count", 32'(pit_count), 32'd5);
        count_until(3, 50, n, seen);
        chk("R2 pit expiry tick", 32'(n), 32'd5);
        chk("R2 pit irq raised", 32'(pit_irq), 32'd1);
        chk("R3 one-shot count zero", 32'(pit_count), 32'd0);
        run_ticks(3);
        chk("R3 one-shot stays stopped", 32'(pit_count), 32'd0);

        // R9 clear PIT flag
        wr_sts(32'h0800_0000);
        chk("R9 pit flag cleared", 32'(sts_q[27]), 32'd0);
        chk("R9 pit irq dropped", 32'(pit_irq), 32'd0);

        // R3 auto-reload
        wr_ctrl(32'h0440_0000);
        chk("R3 restart from control write", 32'(pit_count), 32'd5);
        count_until(3, 50, n, seen);
        chk("R3 auto-reload expiry tick", 32'(n), 32'd5);
        chk("R3 count reloaded", 32'(pit_count), 32'd5);
        run_ticks(2);
        chk("R3 keeps running", 32'(pit_count), 32'd3);

        // R4 enable cleared stops the PIT; R2 irq masked by enable
        wr_ctrl(32'h0040_0000);
        chk("R2 irq masked without enable", 32'(pit_irq), 32'd0);
        chk("R2 flag still set", 32'(sts_q[27]), 32'd1);
        run_ticks(4);
        chk("R4 count held when disabled", 32'(pit_count), 32'd3);

        // R4 reload of 1 and 0 do not run
        wr_ctrl(32'h0400_0000);
        wr_sts(32'h0800_0000);
        wr_pit(16'd1);
        run_ticks(6);
        chk("R4 reload 1 holds count", 32'(pit_count), 32'd1);
        chk("R4 reload 1 no expiry", 32'(sts_q[27]), 32'd0);
        wr_pit(16'd0);
        run_ticks(6);
        chk("R4 reload 0 holds count", 32'(pit_count), 32'd0);
        chk("R4 reload 0 no expiry", 32'(sts_q[27]), 32'd0);

        // R5 FIT irq gating, R9 clear
        do_reset();
        wr_ctrl(32'h0);
        count_until(0, 50, n, seen);
        chk("R5 fit flag without irq enable", 32'(fit_irq), 32'd0);
        wr_ctrl(32'h0080_0000);
        chk("R5 fit irq with enable", 32'(fit_irq), 32'd1);
        wr_sts(32'h0400_0000);
        chk("R9 fit flag cleared", 32'(sts_q[26]), 32'd0);
        chk("R9 fit irq dropped", 32'(fit_irq), 32'd0);

        // R6 / R7 watchdog full sequence, chip reset
        do_reset();
        wr_ctrl(32'h2800_0000);
        count_until(1, 50, n, seen);
        chk("R6 arm after one period", 32'(n), 32'd8);
        chk("R6 no irq at arm", 32'(wdt_irq), 32'd0);
        count_until(2, 50, n, seen);
        chk("R6 alert after next period", 32'(n), 32'd8);
        chk("R6 watchdog irq", 32'(wdt_irq), 32'd1);
        count_until(4, 50, n, seen);
        chk("R7 final after next period", 32'(n), 32'd8);
        chk("R7 chip reset pulse", 32'(seen), 32'b010);
        chk("R7 kind copied to status", 32'(sts_q[29:28]), 32'd2);
        @(negedge clk);
        chk("R7 pulse lasts one cycle", 32'(rst_chip_req), 32'd0);

        // R7 core reset with selector 1, counted from start
        do_reset();
        wr_ctrl(32'h5000_0000);
        count_until(4, 200, n, seen);
        chk("R7 core reset after three periods", 32'(n), 32'd48);
        chk("R7 core reset kind", 32'(seen), 32'b001);

        // R7 kind 0 requests nothing
        do_reset();
        wr_ctrl(32'h0);
        count_until(4, 40, n, seen);
        chk("R7 kind 0 no reset", 32'(seen), 32'b000);
        chk("R7 both flags set", 32'(sts_q[31:30]), 32'd3);
        chk("R7 kind 0 copied", 32'(sts_q[29:28]), 32'd0);

        // R8 software requests
        do_reset();
        wr_dbg(2'd3);
        chk("R8 system request", {29'h0, rst_sys_req, rst_chip_req, rst_core_req}, 32'b100);
        @(negedge clk);
        chk("R8 system pulse ends", 32'(rst_sys_req), 32'd0);
        wr_dbg(2'd1);
        chk("R8 core request", {29'h0, rst_sys_req, rst_chip_req, rst_core_req}, 32'b001);
        wr_dbg(2'd2);
        chk("R8 chip request", {29'h0, rst_sys_req, rst_chip_req, rst_core_req}, 32'b010);
        wr_dbg(2'd0);
        chk("R8 kind 0 no request", {29'h0, rst_sys_req, rst_chip_req, rst_core_req}, 32'b000);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule